// File: doc/BRIEF.md
# SD Host Receive Data Path with Halfword and Word-FIFO Modes

This block is the receive half of an SD/MMC host controller's data engine. Card data arrives already deserialized, one byte at a time, on a valid/ready stream. A small register port lets the CPU pick a transfer mode, set the block length and block count, start a transfer, read the data and watch status. Command handling, CRC, the serial bus, clock division and the transmit direction belong to other blocks.

Two modes coexist. In halfword mode, bytes go into a two-byte holding register. A CPU read of the halfword port is held off with a wait signal until two fresh bytes are present. Progress is tracked by a hidden block counter, and the status flags are sticky. In word mode, a whole block is packed into a 32-bit FIFO, and the byte stream is stalled until the CPU has drained that block. Two self-clearing flags report the FIFO. The sticky end-of-data flag fires, and command-busy drops, as soon as the last block has landed in the FIFO. The visible word-mode block counter counts down but stops at one.

Register map (word addresses on `regAddr`):
- 0: mode select A, bit 1.
- 1: status. Bit 0 is receive-ready, bit 2 is data-end, bit 29 is command-ready and bit 30 is command-busy. Writing a 1 to bit 0 or bit 2 clears that flag.
- 2: halfword data.
- 3: mode select B in bit 1, FIFO-ready in bit 8 and FIFO-pending in bit 9. Bits 8 and 9 are read-only.
- 4: block length in bytes. It must be a multiple of 4, from 4 up to `MAX_BLOCK_BYTES`.
- 5: halfword-mode block count.
- 6: word-mode block count.
- 7: FIFO word data.
- 8: a write of any value starts a transfer.

Top module: `sd_read_path`

## Requirements
- R1: Word mode is used only when bit 1 of register 0 and bit 1 of register 3 are both 1 at the start write. With either bit at 0 the transfer runs in halfword mode, and the FIFO flags (register 3 bits 8 and 9) stay 0.
- R2: After reset, status reads 0x20000000 and register 3 reads 0. The block length reads `MAX_BLOCK_BYTES`, the word-mode count reads 0, and `inReady` is 0.
- R3: In word mode, once the last byte of a block is taken, register 3 bits 8 and 9 both read 1. `inReady` then stays 0 until that block has been read out, and the FIFO never holds more than one block.
- R4: FIFO words are returned in arrival order, with the first byte of each group of four in bits 7:0. Bit 8 clears at the first word read of a block. Bit 9 clears when the last word of the block is read.
- R5: In word mode, a non-final block sets receive-ready at fill time, with command-busy still 1. The final block instead sets data-end and clears command-busy at fill time, before any word is read.
- R6: The word-mode count (register 6) drops by one when a non-final block is drained. It is not decremented for the final block, so it finishes at 1.
- R7: Receive-ready and data-end stay 1 until the CPU writes a 1 to their status bit. Writing 0 to that bit leaves them set.
- R8: In halfword mode, a read of register 2 keeps `regWait` at 1 until two new bytes have been taken. The halfword returned has the first byte in bits 7:0.
- R9: In halfword mode, data-end rises, and command-busy falls, only when the last halfword of the last block is read. Register 5 keeps its written value.
- R10: Status bit 29 always reads as the inverse of status bit 30.
- R11: In halfword mode, receive-ready is set when the first byte of each block is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 4 | Register word address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRd | input | 1 | Register read strobe; data ports pop on it |
| regRdData | output | 32 | Register read data |
| regWait | output | 1 | Holds off a halfword read until data exists |
| byteIn | input | 8 | Deserialized card byte |
| inValid | input | 1 | byteIn is valid |
| inReady | output | 1 | Byte is taken when inValid and inReady |

## Verification
A vector table runs word-mode transfers of one and several blocks, at lengths of one word, a few words and a full 512-byte block. Single-block runs expose the data-end-at-fill behaviour and the count floor of one. Multi-block runs separate receive-ready from data-end and test the counter decrement. Halfword transfers are started with each mode bit set alone and with neither set, which shows that both bits are needed for word mode. A directed read issued before any byte arrives tests the wait stall. The first byte of each block tests receive-ready, and the order of each byte pattern tests packing.

// File: rtl/sd_rd_pkg.sv
package sd_rd_pkg;
  localparam logic [3:0] ADDR_MODE_A = 4'd0;
  localparam logic [3:0] ADDR_STATUS = 4'd1;
  localparam logic [3:0] ADDR_HALF   = 4'd2;
  localparam logic [3:0] ADDR_MODE_B = 4'd3;
  localparam logic [3:0] ADDR_LEN    = 4'd4;
  localparam logic [3:0] ADDR_CNT16  = 4'd5;
  localparam logic [3:0] ADDR_CNT32  = 4'd6;
  localparam logic [3:0] ADDR_WORD   = 4'd7;
  localparam logic [3:0] ADDR_START  = 4'd8;

  typedef struct packed {
    logic clearAll;
    logic takeByte;
    logic packWide;
    logic popWord;
    logic popHalf;
  } dpStrobe_t;
endpackage

// File: rtl/sd_rd_datapath.sv
module sd_rd_datapath
  import sd_rd_pkg::*;
#(
  parameter int MAX_BLOCK_BYTES = 512,
  localparam int FIFO_WORDS = MAX_BLOCK_BYTES / 4,
  localparam int PTR_W = $clog2(FIFO_WORDS),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       byteIn,
  output logic [31:0]      headWord,
  output logic [15:0]      halfWord,
  output logic             halfFull,
  output logic [LVL_W-1:0] fifoLevel
);
  logic [31:0]      mem [FIFO_WORDS];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [1:0]       byteSel;
  logic [23:0]      packLow;
  logic             halfLow;
  logic             wrEn;

  assign wrEn     = !strobe.clearAll && strobe.takeByte && strobe.packWide && (byteSel == 2'd3);
  assign headWord = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_WORDS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= {byteIn, packLow};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fifoLevel <= '0;
      byteSel <= '0; packLow <= '0;
    end else if (strobe.clearAll) begin
      wrPtr <= '0; rdPtr <= '0; fifoLevel <= '0; byteSel <= '0;
    end else begin
      if (strobe.takeByte && strobe.packWide) begin
        if (byteSel != 2'd3) packLow[{byteSel, 3'b000} +: 8] <= byteIn;
        byteSel <= byteSel + 2'd1;
      end
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (strobe.popWord) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, strobe.popWord})
        2'b10:   fifoLevel <= fifoLevel + LVL_W'(1);
        2'b01:   fifoLevel <= fifoLevel - LVL_W'(1);
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfWord <= '0; halfLow <= 1'b0; halfFull <= 1'b0;
    end else if (strobe.clearAll || strobe.popHalf) begin
      halfLow <= 1'b0; halfFull <= 1'b0;
    end else if (strobe.takeByte && !strobe.packWide) begin
      if (!halfLow) begin
        halfWord[7:0] <= byteIn;
        halfLow <= 1'b1;
      end else begin
        halfWord[15:8] <= byteIn;
        halfFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_rd_ctrl.sv
module sd_rd_ctrl
  import sd_rd_pkg::*;
#(
  parameter int MAX_BLOCK_BYTES = 512,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(MAX_BLOCK_BYTES) + 1,
  localparam int LVL_W = $clog2(MAX_BLOCK_BYTES / 4) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regAddr,
  input  logic             regWr,
  input  logic [31:0]      regWrData,
  input  logic             regRd,
  output logic [31:0]      regRdData,
  output logic             regWait,
  input  logic             inValid,
  output logic             inReady,
  input  logic [31:0]      headWord,
  input  logic [15:0]      halfWord,
  input  logic             halfFull,
  input  logic [LVL_W-1:0] fifoLevel,
  output dpStrobe_t        strobe,
  output logic             cmdBusy,
  output logic             dataEnd,
  output logic             fifoPending,
  output logic             xferWide,
  output logic [CNT_W-1:0] blkCnt32
);
  logic             modeA, modeB, rxReady, fifoReady, blockHeld;
  logic [LEN_W-1:0] blkLen, byteCnt, halfCnt;
  logic [CNT_W-1:0] blkCnt16, remain16;
  logic startHit, take, lastByte, fill, wordRd, drain, halfAsk, halfRd, lastHalf;
  logic ackHit, rxSet, endSet;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;
  assign startHit = regWr && (regAddr == ADDR_START);
  assign ackHit   = regWr && (regAddr == ADDR_STATUS);
  assign inReady  = cmdBusy && (xferWide ? !blockHeld : !halfFull);
  assign take     = inValid && inReady;
  assign lastByte = (byteCnt == blkLen - LEN_W'(1));
  assign fill     = take && xferWide && lastByte;
  assign wordRd   = regRd && (regAddr == ADDR_WORD) && xferWide && fifoPending && (fifoLevel != '0);
  assign drain    = wordRd && (fifoLevel == LVL_W'(1));
  assign halfAsk  = regRd && (regAddr == ADDR_HALF) && cmdBusy && !xferWide;
  assign regWait  = halfAsk && !halfFull;
  assign halfRd   = halfAsk && halfFull;
  assign lastHalf = (halfCnt == (blkLen >> 1) - LEN_W'(1));
  assign rxSet    = (take && !xferWide && (byteCnt == '0)) ||
                    (fill && (blkCnt32 > CNT_W'(1)));
  assign endSet   = (fill && (blkCnt32 <= CNT_W'(1))) ||
                    (halfRd && lastHalf && (remain16 <= CNT_W'(1)));

  always_comb begin
    strobe.clearAll = startHit;
    strobe.takeByte = take;
    strobe.packWide = xferWide;
    strobe.popWord  = wordRd;
    strobe.popHalf  = halfRd;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeA <= 1'b0; modeB <= 1'b0;
      blkLen <= LEN_W'(MAX_BLOCK_BYTES);
      blkCnt16 <= '0; blkCnt32 <= '0;
    end else begin
      if (regWr && regAddr == ADDR_MODE_A) modeA <= regWrData[1];
      if (regWr && regAddr == ADDR_MODE_B) modeB <= regWrData[1];
      if (regWr && regAddr == ADDR_LEN)    blkLen <= regWrData[LEN_W-1:0];
      if (regWr && regAddr == ADDR_CNT16)  blkCnt16 <= regWrData[CNT_W-1:0];
      if (regWr && regAddr == ADDR_CNT32)  blkCnt32 <= regWrData[CNT_W-1:0];
      else if (drain && cmdBusy)           blkCnt32 <= blkCnt32 - CNT_W'(1);
    end
  end

  // sticky flags: a set in the same cycle wins over an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady <= 1'b0; dataEnd <= 1'b0;
    end else begin
      rxReady <= rxSet  || (rxReady && !(ackHit && regWrData[0]));
      dataEnd <= endSet || (dataEnd && !(ackHit && regWrData[2]));
    end
  end

  // transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBusy <= 1'b0; xferWide <= 1'b0; blockHeld <= 1'b0;
      fifoReady <= 1'b0; fifoPending <= 1'b0;
      byteCnt <= '0; halfCnt <= '0; remain16 <= '0;
    end else if (startHit) begin
      cmdBusy <= 1'b1; xferWide <= modeA && modeB; blockHeld <= 1'b0;
      fifoReady <= 1'b0; fifoPending <= 1'b0;
      byteCnt <= '0; halfCnt <= '0; remain16 <= blkCnt16;
    end else begin
      if (take) byteCnt <= lastByte ? '0 : byteCnt + LEN_W'(1);
      if (fill) begin
        blockHeld <= 1'b1; fifoReady <= 1'b1; fifoPending <= 1'b1;
        if (blkCnt32 <= CNT_W'(1)) cmdBusy <= 1'b0;
      end
      if (wordRd) begin
        fifoReady <= 1'b0;
        if (drain) begin
          fifoPending <= 1'b0; blockHeld <= 1'b0;
        end
      end
      if (halfRd) begin
        halfCnt <= lastHalf ? '0 : halfCnt + LEN_W'(1);
        if (lastHalf) begin
          if (remain16 <= CNT_W'(1)) cmdBusy <= 1'b0;
          else remain16 <= remain16 - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_MODE_A: regRdData[1] = modeA;
      ADDR_STATUS: begin
        regRdData[0]  = rxReady;
        regRdData[2]  = dataEnd;
        regRdData[29] = !cmdBusy;
        regRdData[30] = cmdBusy;
      end
      ADDR_HALF:   regRdData = 32'(halfWord);
      ADDR_MODE_B: begin
        regRdData[1] = modeB;
        regRdData[8] = fifoReady;
        regRdData[9] = fifoPending;
      end
      ADDR_LEN:    regRdData = 32'(blkLen);
      ADDR_CNT16:  regRdData = 32'(blkCnt16);
      ADDR_CNT32:  regRdData = 32'(blkCnt32);
      ADDR_WORD:   regRdData = headWord;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sd_read_path.sv
module sd_read_path
  import sd_rd_pkg::*;
#(
  parameter int MAX_BLOCK_BYTES = 512,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(MAX_BLOCK_BYTES / 4) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWrData,
  input  logic        regRd,
  output logic [31:0] regRdData,
  output logic        regWait,
  input  logic [7:0]  byteIn,
  input  logic        inValid,
  output logic        inReady
);
  dpStrobe_t        strobe;
  logic [31:0]      headWord;
  logic [15:0]      halfWord;
  logic             halfFull;
  logic [LVL_W-1:0] fifoLevel;
  logic             cmdBusy, dataEnd, fifoPending, xferWide;
  logic [CNT_W-1:0] blkCnt32;

  sd_rd_datapath #(.MAX_BLOCK_BYTES(MAX_BLOCK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(byteIn),
    .headWord(headWord), .halfWord(halfWord), .halfFull(halfFull), .fifoLevel(fifoLevel)
  );

  sd_rd_ctrl #(.MAX_BLOCK_BYTES(MAX_BLOCK_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRd(regRd), .regRdData(regRdData), .regWait(regWait),
    .inValid(inValid), .inReady(inReady),
    .headWord(headWord), .halfWord(halfWord), .halfFull(halfFull), .fifoLevel(fifoLevel),
    .strobe(strobe), .cmdBusy(cmdBusy), .dataEnd(dataEnd), .fifoPending(fifoPending),
    .xferWide(xferWide), .blkCnt32(blkCnt32)
  );
endmodule

// File: rtl/sd_read_path_chk.sv
module sd_read_path_chk #(
  parameter int MAX_BLOCK_BYTES = 512,
  parameter int CNT_W = 16,
  localparam int FIFO_WORDS = MAX_BLOCK_BYTES / 4,
  localparam int LVL_W = $clog2(FIFO_WORDS) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             regRd,
  input logic             regWr,
  input logic             regWait,
  input logic             cmdBusy,
  input logic             dataEnd,
  input logic             fifoPending,
  input logic             xferWide,
  input logic             halfFull,
  input logic [LVL_W-1:0] fifoLevel,
  input logic [CNT_W-1:0] blkCnt32
);
  // R3: a held block stops the byte stream
  a_r3_hold_stalls_input: assert property (@(posedge clk) disable iff (!rstN)
    (xferWide && fifoPending) |-> !inReady);

  // R3: the FIFO never exceeds one block
  a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(FIFO_WORDS));

  // R5: data-end in word mode comes with command-busy low
  a_r5_end_with_idle: assert property (@(posedge clk) disable iff (!rstN)
    (xferWide && $rose(dataEnd)) |-> !cmdBusy);

  // R6: without a register write the word-mode count never rises
  a_r6_count_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> (blkCnt32 <= $past(blkCnt32)));

  // R8: wait is only raised for a read facing an empty holder
  a_r8_wait_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    regWait |-> (regRd && !halfFull));
endmodule

bind sd_read_path sd_read_path_chk #(.MAX_BLOCK_BYTES(MAX_BLOCK_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .regRd(regRd), .regWr(regWr),
  .regWait(regWait), .cmdBusy(cmdBusy), .dataEnd(dataEnd), .fifoPending(fifoPending),
  .xferWide(xferWide), .halfFull(halfFull), .fifoLevel(fifoLevel), .blkCnt32(blkCnt32)
);

// File: tb/test_sd_read_path.sv
`timescale 1ns/1ps
module test_sd_read_path;
  import sd_rd_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRd = 1'b0;
  logic [31:0] regRdData;
  logic        regWait;
  logic [7:0]  byteIn = '0;
  logic        inValid = 1'b0;
  logic        inReady;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sd_read_path i_sd_read_path (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRd(regRd), .regRdData(regRdData), .regWait(regWait),
    .byteIn(byteIn), .inValid(inValid), .inReady(inReady)
  );

  // fields: [23:20] mode bits (bit21 = A, bit20 = B), [19:8] length in bytes, [7:0] blocks
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    24'h3_008_01, 24'h3_004_03, 24'h1_008_02, 24'h2_004_01,
    24'h0_00C_02, 24'h3_00C_02, 24'h3_200_01
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int e, input int b, input int k);
    return 8'(e * 37 + b * 11 + k);
  endfunction

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1;
    while (regWait) begin @(negedge clk); #1; end
    d = regRdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); inValid = 1'b1; byteIn = b; #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(negedge clk); inValid = 1'b0;
  endtask

  task automatic readStatus(output logic [31:0] s);
    regRead(ADDR_STATUS, s);
    check("R10 ready is inverse of busy", 32'(s[29]), 32'(!s[30]));
  endtask

  task automatic runWide(input int e, input int len, input int n);
    logic [31:0] v;
    regWrite(ADDR_START, 0);
    for (int b = 0; b < n; b++) begin
      bit last = (b == n - 1);
      for (int k = 0; k < len; k++) sendByte(pat(e, b, k));
      check("R3 input stalled while block held", 32'(inReady), 0);
      regRead(ADDR_MODE_B, v);
      check("R3 both fifo flags after fill", 32'(v[9:8]), 32'd3);
      readStatus(v);
      if (last) begin
        check("R5 final block raises data-end at fill", 32'(v[2]), 1);
        check("R5 final block drops busy at fill", 32'(v[30]), 0);
      end else begin
        check("R5 non-final block raises receive-ready", 32'(v[0]), 1);
        check("R5 busy stays for non-final block", 32'(v[30]), 1);
      end
      regRead(ADDR_CNT32, v);
      check("R6 count before drain", v, 32'(n - b));
      for (int w = 0; w < len / 4; w++) begin
        logic [31:0] expW = {pat(e, b, 4*w+3), pat(e, b, 4*w+2), pat(e, b, 4*w+1), pat(e, b, 4*w)};
        regRead(ADDR_WORD, v);
        check("R4 fifo word order and packing", v, expW);
        if (w == 0 && len > 4) begin
          logic [31:0] m;
          regRead(ADDR_MODE_B, m);
          check("R4 ready clears at first read, pending stays", 32'(m[9:8]), 32'd2);
        end
      end
      regRead(ADDR_MODE_B, v);
      check("R4 pending clears after drain", 32'(v[9:8]), 0);
      regRead(ADDR_CNT32, v);
      check("R6 count after drain", v, last ? 32'd1 : 32'(n - b - 1));
      if (!last) begin
        regWrite(ADDR_STATUS, 32'h0);
        readStatus(v);
        check("R7 write of 0 keeps receive-ready", 32'(v[0]), 1);
        regWrite(ADDR_STATUS, 32'h1);
        readStatus(v);
        check("R7 write of 1 clears receive-ready", 32'(v[0]), 0);
      end
    end
    regWrite(ADDR_STATUS, 32'h4);
    readStatus(v);
    check("R7 data-end acknowledged", 32'(v[2]), 0);
  endtask

  task automatic runHalf(input int e, input int len, input int n);
    logic [31:0] v;
    regWrite(ADDR_START, 0);
    for (int b = 0; b < n; b++) begin
      for (int h = 0; h < len / 2; h++) begin
        bit finalHalf = (b == n - 1) && (h == len / 2 - 1);
        sendByte(pat(e, b, 2*h));
        if (h == 0) begin
          readStatus(v);
          check("R11 receive-ready on first byte of block", 32'(v[0]), 1);
          regWrite(ADDR_STATUS, 32'h1);
        end
        sendByte(pat(e, b, 2*h+1));
        if (h == 0) begin
          regRead(ADDR_MODE_B, v);
          check("R1 no fifo flag in halfword mode", 32'(v[9:8]), 0);
        end
        if (finalHalf) begin
          readStatus(v);
          check("R9 no data-end before last read", 32'(v[2]), 0);
          check("R9 busy before last read", 32'(v[30]), 1);
        end
        regRead(ADDR_HALF, v);
        check("R8 halfword value", v, {16'h0, pat(e, b, 2*h+1), pat(e, b, 2*h)});
      end
    end
    readStatus(v);
    check("R9 data-end after last halfword", 32'(v[2]), 1);
    check("R9 ready after last halfword", 32'(v[29]), 1);
    regRead(ADDR_CNT16, v);
    check("R9 halfword count unchanged", v, 32'(n));
    regWrite(ADDR_STATUS, 32'h4);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R2 input not ready after reset", 32'(inReady), 0);
    readStatus(v);
    check("R2 status after reset", v, 32'h2000_0000);
    regRead(ADDR_MODE_B, v);
    check("R2 mode B after reset", v, 0);
    regRead(ADDR_LEN, v);
    check("R2 length after reset", v, 32'd512);
    regRead(ADDR_CNT32, v);
    check("R2 word count after reset", v, 0);

    for (int i = 0; i < NV; i++) begin
      logic mA = VEC[i][21];
      logic mB = VEC[i][20];
      int len = int'(VEC[i][19:8]);
      int n = int'(VEC[i][7:0]);
      regWrite(ADDR_MODE_A, {30'h0, mA, 1'b0});
      regWrite(ADDR_MODE_B, {30'h0, mB, 1'b0});
      regWrite(ADDR_LEN, 32'(len));
      regWrite(ADDR_CNT16, 32'(n));
      regWrite(ADDR_CNT32, 32'(n));
      if (mA && mB) runWide(i, len, n);
      else runHalf(i, len, n);
    end

    // R8 directed: a read issued before any byte is held by wait
    regWrite(ADDR_MODE_A, 32'h2);
    regWrite(ADDR_MODE_B, 32'h0);
    regWrite(ADDR_LEN, 32'd4);
    regWrite(ADDR_CNT16, 32'd1);
    regWrite(ADDR_START, 0);
    fork
      regRead(ADDR_HALF, v);
      begin
        repeat (3) @(negedge clk);
        #1 check("R8 wait with no bytes", 32'(regWait), 1);
        sendByte(8'hA5);
        #1 check("R8 wait with one byte", 32'(regWait), 1);
        sendByte(8'h5A);
      end
    join
    check("R8 stalled read data", v, 32'h0000_5AA5);
    sendByte(8'h11);
    sendByte(8'h22);
    regRead(ADDR_HALF, v);
    check("R8 second halfword", v, 32'h0000_2211);
    readStatus(v);
    check("R9 data-end after stalled transfer", 32'(v[2]), 1);
    repeat (5) @(negedge clk);
    readStatus(v);
    check("R7 data-end still held", 32'(v[2]), 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule